// File: doc/BRIEF.md
# Pipelined ADC Digital Error Corrector

This block sits behind the analog stages of a ten-stage pipelined converter. Each analog stage makes a three-level decision using two comparators. A sample moves down the pipe one stage per half conversion clock, so the ten decisions for one sample reach the digital side on ten consecutive half-cycles. The block models the half-cycle grid with a twice-rate clock and a tick enable. It holds each stage's decision back until the decisions of all ten stages for that sample are present together.

The aligned decisions are then summed. The weights halve from stage to stage and the ranges of neighbouring stages overlap by one bit. Because of this overlap, a comparator offset in an early stage is absorbed by the stages after it. The sum is shifted to straight offset binary and clamped to ten bits.

A sample strobe marks the tick on which stage 1 presents its decision. The corrected word, a valid flag and an illegal-code flag come out 11 enabled ticks later, which is 5.5 conversion clocks.

Top module: `adc_pipe_corrector`

## Requirements
- R1: Stage k (k = 1..10) drives the field `stage_dec_i[2k-1:2k-2]`, coded 2'b00 = -1, 2'b01 = 0 and 2'b10 = +1.
- R2: For a sample whose strobe is high on enabled tick T, stage k's field is taken on enabled tick T+k-1.
- R3: The output word is 512 + sum over k of d_k * 2^(10-k), in straight offset binary. A sample whose decisions are all 0 yields 0x200.
- R4: A sum above 1023 is clamped to 0x3FF and a sum below 0 is clamped to 0x000.
- R5: `word_vld_o` is high for exactly one tick per strobe. That tick is 11 enabled ticks after the strobe tick, and the sample's word is on `word_o` during that tick.
- R6: A field equal to 2'b11 is illegal. It counts as 0, and `code_err_o` is raised in the tick that carries that sample's word.
- R7: `code_err_o` is never high while `word_vld_o` is low. An illegal code in a slot that belongs to no strobed sample raises no flag.
- R8: While `half_en_i` is low, no state advances. All outputs hold, and the strobe and decision inputs are ignored.
- R9: Between valid ticks, `word_o` keeps the last valid word. After reset it holds 0.
- R10: After reset, `word_o`, `word_vld_o` and `code_err_o` are all 0.
- R11: A comparator threshold can sit anywhere between 0 and one stage weight minus 1 LSB, and the word still does not change. Every code from 0 to 1023 can be reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-rate clock; one enabled tick is half a conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_en_i | input | 1 | Tick enable; all state advances only when high |
| smp_strobe_i | input | 1 | High on the tick on which stage 1 presents a new sample |
| stage_dec_i | input | 20 | Ten 2-bit stage decisions, stage 1 in the low field |
| word_o | output | 10 | Corrected straight offset binary word |
| word_vld_o | output | 1 | Marks the tick that carries a sample's word |
| code_err_o | output | 1 | The word in this tick was built from an illegal stage code |

## Verification
The checker assumes the strobe and the stage fields are sampled only on enabled ticks. It makes no assumption about what they carry on stalled ticks or in slots that belong to no sample. The stimulus model therefore fills unused slots and stall ticks with the illegal code, which also exercises R7 and R8.

The behavioural residue model needs every comparator threshold to stay between 0 and one stage weight minus 1 LSB. With thresholds in that range the residue entering each stage stays within twice that stage's weight, and the last stage leaves no error. The sweeps set thresholds at both ends of the range and in mixed patterns. They cover every input value from -1023 to +1023 LSB, which also drives both clamps.

// File: rtl/adc_ec_pkg.sv
package adc_ec_pkg;

  // three-level stage decision, one illegal encoding
  typedef enum logic [1:0] {
    DEC_NEG = 2'b00,
    DEC_MID = 2'b01,
    DEC_POS = 2'b10,
    DEC_BAD = 2'b11
  } dec_code_e;

  localparam int unsigned DEC_W = 2;

  // illegal code contributes the mid level
  function automatic logic [DEC_W-1:0] dec_level(input logic [DEC_W-1:0] raw);
    if (raw == DEC_BAD) return DEC_MID;
    return raw;
  endfunction

  function automatic logic dec_illegal(input logic [DEC_W-1:0] raw);
    return (raw == DEC_BAD);
  endfunction

endpackage

// File: rtl/ec_rst_sync.sv
module ec_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/ec_skew_line.sv
module ec_skew_line #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] tap_q [DEPTH];
  logic [W-1:0] tap_d [DEPTH];

  always_comb begin
    tap_d[0] = d_i;
    for (int i = 1; i < int'(DEPTH); i++) tap_d[i] = tap_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) tap_q[i] <= '0;
    end else if (en_i) begin
      for (int i = 0; i < int'(DEPTH); i++) tap_q[i] <= tap_d[i];
    end
  end

  assign q_o = tap_q[DEPTH-1];

endmodule

// File: rtl/ec_stage_adder.sv
module ec_stage_adder
  import adc_ec_pkg::*;
#(
  parameter int unsigned NSTAGE = 10,
  parameter int unsigned SUM_W  = NSTAGE + 1
) (
  input  logic [DEC_W*NSTAGE-1:0] dec_i,
  output logic [SUM_W-1:0]        sum_o,
  output logic                    bad_o
);

  logic [DEC_W-1:0] lvl     [NSTAGE];
  logic [SUM_W-1:0] term    [NSTAGE];
  logic [NSTAGE-1:0] bad_vec;

  // stage index i carries weight 2^(NSTAGE-1-i)
  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    assign lvl[i]     = dec_level(dec_i[DEC_W*i +: DEC_W]);
    assign bad_vec[i] = dec_illegal(dec_i[DEC_W*i +: DEC_W]);
    assign term[i]    = SUM_W'(lvl[i]) << (NSTAGE-1-i);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < int'(NSTAGE); i++) sum_o = sum_o + term[i];
  end

  assign bad_o = |bad_vec;

endmodule

// File: rtl/ec_sat_map.sv
module ec_sat_map #(
  parameter int unsigned NSTAGE = 10,
  parameter int unsigned SUM_W  = NSTAGE + 1
) (
  input  logic [SUM_W-1:0]  sum_i,
  output logic [NSTAGE-1:0] word_o
);

  // unsigned level sum carries +1 per stage; remove it and recentre
  localparam logic [SUM_W-1:0] BIAS = SUM_W'((1 << (NSTAGE-1)) - 1);
  localparam logic [SUM_W-1:0] TOPV = SUM_W'((1 << NSTAGE) - 1);

  logic [SUM_W-1:0] diff;

  always_comb begin
    diff = sum_i - BIAS;
    if (sum_i < BIAS)     word_o = '0;
    else if (diff > TOPV) word_o = '1;
    else                  word_o = diff[NSTAGE-1:0];
  end

endmodule

// File: rtl/adc_pipe_corrector.sv
module adc_pipe_corrector
  import adc_ec_pkg::*;
#(
  parameter int unsigned NSTAGE = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    half_en_i,
  input  logic                    smp_strobe_i,
  input  logic [DEC_W*NSTAGE-1:0] stage_dec_i,
  output logic [NSTAGE-1:0]       word_o,
  output logic                    word_vld_o,
  output logic                    code_err_o
);

  localparam int unsigned DEC_BITS = DEC_W * NSTAGE;
  localparam int unsigned SUM_W    = NSTAGE + 1;
  localparam int unsigned ALIGN    = NSTAGE - 1;

  logic rst_core_n;

  ec_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  // strobe travels with stage 1
  logic vld_aln;

  ec_skew_line #(.W(1), .DEPTH(ALIGN)) u_strobe_line (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en_i  (half_en_i),
    .d_i   (smp_strobe_i),
    .q_o   (vld_aln)
  );

  // later stages need fewer ticks of delay; the last needs none
  logic [DEC_BITS-1:0] dec_aln;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_lane
    if (i == NSTAGE-1) begin : g_direct
      assign dec_aln[DEC_W*i +: DEC_W] = stage_dec_i[DEC_W*i +: DEC_W];
    end else begin : g_delay
      ec_skew_line #(.W(DEC_W), .DEPTH(NSTAGE-1-i)) u_lane (
        .clk   (clk),
        .rst_n (rst_core_n),
        .en_i  (half_en_i),
        .d_i   (stage_dec_i[DEC_W*i +: DEC_W]),
        .q_o   (dec_aln[DEC_W*i +: DEC_W])
      );
    end
  end

  logic [SUM_W-1:0] sum_c;
  logic             bad_c;

  ec_stage_adder #(.NSTAGE(NSTAGE), .SUM_W(SUM_W)) u_adder (
    .dec_i (dec_aln),
    .sum_o (sum_c),
    .bad_o (bad_c)
  );

  // sum register
  logic [SUM_W-1:0] sum_q, sum_d;
  logic             bad_q, bad_d;
  logic             vla_q, vla_d;

  always_comb begin
    sum_d = half_en_i ? sum_c   : sum_q;
    bad_d = half_en_i ? bad_c   : bad_q;
    vla_d = half_en_i ? vld_aln : vla_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sum_q <= '0;
      bad_q <= 1'b0;
      vla_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      bad_q <= bad_d;
      vla_q <= vla_d;
    end
  end

  logic [NSTAGE-1:0] word_c;

  ec_sat_map #(.NSTAGE(NSTAGE), .SUM_W(SUM_W)) u_sat (
    .sum_i  (sum_q),
    .word_o (word_c)
  );

  // output latch: word updates only on a valid tick
  logic [NSTAGE-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  always_comb begin
    vld_d  = half_en_i ? vla_q           : vld_q;
    err_d  = half_en_i ? (vla_q & bad_q) : err_q;
    word_d = (half_en_i && vla_q) ? word_c : word_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
  assign code_err_o = err_q;

endmodule

// File: rtl/adc_pipe_corrector_chk.sv
module adc_pipe_corrector_chk #(
  parameter int unsigned NSTAGE = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              half_en_i,
  input logic              smp_strobe_i,
  input logic [NSTAGE-1:0] word_o,
  input logic              word_vld_o,
  input logic              code_err_o
);

  localparam int unsigned LAT = NSTAGE + 1;

  // strobe history counted in enabled ticks
  logic [LAT-1:0] lat_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_sh <= '0;
    else if (half_en_i) lat_sh <= {lat_sh[LAT-2:0], smp_strobe_i};
  end

  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o == lat_sh[LAT-1]); // R5

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    code_err_o |-> word_vld_o); // R7

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en_i |=> ($stable(word_o) && $stable(word_vld_o) && $stable(code_err_o))); // R8

  AST_WORD_MOVES_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> word_vld_o); // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!word_vld_o && !code_err_o && (word_o == '0)); // R10
    end
  end

endmodule

bind adc_pipe_corrector adc_pipe_corrector_chk #(.NSTAGE(NSTAGE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .half_en_i    (half_en_i),
  .smp_strobe_i (smp_strobe_i),
  .word_o       (word_o),
  .word_vld_o   (word_vld_o),
  .code_err_o   (code_err_o)
);

// File: tb/adc_pipe_corrector_tb_top.sv
module adc_pipe_corrector_tb_top;

  localparam int NST    = 10;
  localparam int NSW    = 2047;
  localparam int NPASS  = 4;
  localparam int NSWEEP = NPASS * NSW;
  localparam int NILL   = 40;
  localparam int NS     = NSWEEP + NILL;
  localparam int LAT    = 11;
  localparam int MAXE   = 2 * NS + LAT + 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              half_en;
  logic              strobe;
  logic [2*NST-1:0]  dec;
  logic [NST-1:0]    word;
  logic              vld;
  logic              err;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  bit   seen [1024];
  int   last_word;

  adc_pipe_corrector #(.NSTAGE(NST)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_en_i    (half_en),
    .smp_strobe_i (strobe),
    .stage_dec_i  (dec),
    .word_o       (word),
    .word_vld_o   (vld),
    .code_err_o   (err)
  );

  // comparator threshold for stage k (weight w), kept within [0, w-1]
  function automatic int thr_of(int pass, int x, int k, int w);
    case (pass)
      0:       return w / 2;
      1:       return w - 1;
      2:       return 0;
      default: return (((x + k) & 1) != 0) ? w - 1 : 0;
    endcase
  endfunction

  // behavioural residue model: decision (-1/0/+1) of stage k
  function automatic int stage_d(int pass, int x, int k);
    int r = x;
    int d = 0;
    for (int s = 1; s <= k; s++) begin
      int w;
      int th;
      w  = 1 << (NST - s);
      th = thr_of(pass, x, s, w);
      d  = (r > th) ? 1 : ((r < -th) ? -1 : 0);
      r  = r - d * w;
    end
    return d;
  endfunction

  function automatic void smp_params(int idx, output int pass, output int x, output int badk);
    if (idx < NSWEEP) begin
      pass = idx / NSW;
      x    = (idx % NSW) - 1023;
      badk = 0;
    end else begin
      int j;
      j    = idx - NSWEEP;
      pass = 3;
      x    = ((j * 53) % 1024) - 512;
      badk = (j % NST) + 1;
    end
  endfunction

  // R1 encoding: 00=-1, 01=0, 10=+1, 11 illegal
  function automatic logic [1:0] stage_code(int idx, int k);
    int pass, x, badk;
    smp_params(idx, pass, x, badk);
    if (k == badk) return 2'b11;
    return 2'(stage_d(pass, x, k) + 1);
  endfunction

  function automatic int clamp_code(int v);
    if (v < 0)    return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  function automatic int exp_word(int idx);
    int pass, x, badk, v;
    smp_params(idx, pass, x, badk);
    v = 512 + x;
    if (badk != 0) v = v - stage_d(pass, x, badk) * (1 << (NST - badk));
    return clamp_code(v);
  endfunction

  task automatic check(string tag, int got, int expv, string what);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
    end
  endtask

  // R2: stage k of the sample strobed on tick s is driven on tick s+k-1
  task automatic drive(int e, bit en);
    half_en = en;
    if (!en) begin
      strobe = 1'b1;
      dec    = '1;
    end else begin
      strobe = ((e % 2) == 0) && ((e / 2) < NS);
      for (int k = 1; k <= NST; k++) begin
        int s;
        s = e - (k - 1);
        if (s >= 0 && (s % 2) == 0 && (s / 2) < NS) dec[2*(k-1) +: 2] = stage_code(s / 2, k);
        else                                        dec[2*(k-1) +: 2] = 2'b11;
      end
    end
  endtask

  task automatic observe(int e, bit stall);
    int    t;
    string pre;
    pre = stall ? "R8," : "";
    t   = e - LAT;
    if (t >= 0 && (t % 2) == 0 && (t / 2) < NS) begin
      int    idx, ew, pass, x, badk;
      string wtag;
      idx = t / 2;
      ew  = exp_word(idx);
      smp_params(idx, pass, x, badk);
      if (badk != 0)                        wtag = "R6";
      else if (512 + x < 0 || 512 + x > 1023) wtag = "R4";
      else if (pass == 0)                   wtag = "R1,R2,R3";
      else                                  wtag = "R11";
      check({pre, "R5"}, int'(vld), 1, "valid");
      check({pre, wtag}, int'(word), ew, "word");
      check({pre, "R6,R7"}, int'(err), (badk != 0) ? 1 : 0, "error flag");
      last_word = ew;
      if (badk == 0) seen[ew] = 1'b1;
    end else begin
      check({pre, "R5"}, int'(vld), 0, "valid");
      check({pre, "R7"}, int'(err), 0, "error flag");
      check({pre, "R9"}, int'(word), last_word, "held word");
    end
  endtask

  initial begin
    int e;
    int stall_cnt;
    int missing;
    rst_n     = 1'b0;
    half_en   = 1'b0;
    strobe    = 1'b0;
    dec       = '0;
    last_word = 0;
    repeat (3) @(negedge clk);
    check("R10", int'(word), 0, "reset word");
    check("R10", int'(vld),  0, "reset valid");
    check("R10", int'(err),  0, "reset error");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", int'(vld), 0, "valid after release");
    e = 0;
    stall_cnt = 0;
    while (e < MAXE) begin
      @(negedge clk);
      if ((e % 101) == 37 && stall_cnt < 3) begin
        observe(e, 1'b1);
        drive(e, 1'b0);
        stall_cnt++;
      end else begin
        observe(e, 1'b0);
        drive(e, 1'b1);
        e++;
        stall_cnt = 0;
      end
    end
    missing = 0;
    for (int c = 0; c < 1024; c++) if (!seen[c]) missing++;
    check("R11", missing, 0, "unreached codes");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule